// File: doc/BRIEF.md
# Shared-DAC Successive-Approximation Frame Sequencer

This block runs one audio sample period as a fixed series of phases around a single 16-bit DAC. A frame tick starts the period. The block closes the input sample switch for an acquisition window and then opens it, so the held level stays fixed. It then resolves that level by successive approximation. The search starts at the top bit and moves down one bit per step. In each step the DAC shows a trial word, and a one-bit comparator decides whether the trial bit stays.

Once the converted word has been delivered, the same DAC is lent to the output side. It first carries the processed left word and then the right word, each in its own slot. Each channel has its own hold-switch strobe. A strobe goes high only after the DAC has settled on that channel's word, and it drops again before the DAC moves on. The converter and both output holds therefore share one converter with no conflict.

Top module: `sar_dac_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, dacWord is 0 and sampleSwitch, holdLeft, holdRight and sampleValid are all 0.
- R2: A tick accepted at an edge sets sampleSwitch high for exactly ACQ_CYCLES clocks from that edge. After that, sampleSwitch stays low until the next accepted tick.
- R3: The search takes exactly 16 steps, each lasting SETTLE_CYCLES clocks. In step k (k = 0 for the top bit), dacWord equals the bits already decided above position 15-k, with bit 15-k set and all lower bits clear.
- R4: The comparator is sampled on the last clock of each step. A value of 1 (held level at or above the DAC) keeps the trial bit, and a value of 0 clears it. With an ideal comparator, the final word therefore equals the held level bit for bit.
- R5: Right after the last step, sampleValid is high for exactly one clock, and sampleOut carries the converted word during that clock.
- R6: After the valid clock, dacWord carries the left word captured at the accepted tick for one slot of SETTLE_CYCLES+HOLD_CYCLES+1 clocks. It then carries the captured right word for one slot of the same length.
- R7: In each slot, the channel's hold strobe is low for the first SETTLE_CYCLES clocks and high for the next HOLD_CYCLES clocks. It is low on the last clock of the slot. The two hold strobes and sampleSwitch are never high together.
- R8: A frame tick that arrives while a frame is in progress has no effect on the phase timing. sampleSwitch rises only once per frame.
- R9: After the right slot the sequencer is idle. All switches are open, sampleValid is 0, and dacWord keeps the right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameTick | input | 1 | Starts a frame when the sequencer is idle |
| compBit | input | 1 | Comparator result, 1 when the held level is at or above the DAC level |
| leftIn | input | 16 | Processed left output word |
| rightIn | input | 16 | Processed right output word |
| dacWord | output | 16 | Word driven to the shared DAC |
| sampleSwitch | output | 1 | Input sample switch enable |
| holdLeft | output | 1 | Left output hold switch strobe |
| holdRight | output | 1 | Right output hold switch strobe |
| sampleOut | output | 16 | Converted input word |
| sampleValid | output | 1 | One-cycle flag for sampleOut |

## Verification
The hardest case to reach is a frame tick that arrives in the middle of a frame, during acquisition, search or an output slot. The sequencer ignores such a tick, so nothing at the ports shows that it was missed. The stimulus drives random ticks on almost every clock of some frames. The bench then checks that the whole cycle-by-cycle timeline matches that of a quiet frame and that sampleSwitch rose only once. The bench models the comparator from the live DAC word on every cycle. Directed held levels at both extremes and at the half-scale boundaries reach the cases where every trial bit is kept or every trial bit is dropped.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_DONE,
    ST_OUTL,
    ST_OUTR
  } seqState_t;

  typedef struct packed {
    logic clearResult;
    logic captureOut;
    logic loadFirstTrial;
    logic decideBit;
    logic loadLeft;
    logic loadRight;
  } dpCtrl_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ACQ_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 2,
  parameter int HOLD_CYCLES   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameTick,
  output dpCtrl_t dpCtrl,
  output logic    sampleSwitch,
  output logic    holdLeft,
  output logic    holdRight,
  output logic    sampleValid
);

  localparam int SLOT_CYCLES = SETTLE_CYCLES + HOLD_CYCLES + 1;
  localparam int CNT_MAX     = (ACQ_CYCLES > SLOT_CYCLES) ? ACQ_CYCLES : SLOT_CYCLES;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);
  localparam int BIT_W       = $clog2(DATA_W);

  localparam logic [CNT_W-1:0] ACQ_LAST    = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] STEP_LAST   = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST   = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_START  = CNT_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] HOLD_END    = CNT_W'(SETTLE_CYCLES + HOLD_CYCLES);
  localparam logic [BIT_W-1:0] BIT_LAST    = BIT_W'(DATA_W - 1);

  seqState_t         state;
  logic [CNT_W-1:0]  cycCnt;
  logic [BIT_W-1:0]  bitCnt;

  logic acqEnd, stepEnd, slotEnd, inHoldWindow;

  assign acqEnd       = (state == ST_ACQ)  && (cycCnt == ACQ_LAST);
  assign stepEnd      = (state == ST_CONV) && (cycCnt == STEP_LAST);
  assign slotEnd      = (cycCnt == SLOT_LAST);
  assign inHoldWindow = (cycCnt >= HOLD_START) && (cycCnt < HOLD_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frameTick) begin
            state  <= ST_ACQ;
            cycCnt <= '0;
          end
        end
        ST_ACQ: begin
          if (acqEnd) begin
            state  <= ST_CONV;
            cycCnt <= '0;
            bitCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (stepEnd) begin
            cycCnt <= '0;
            if (bitCnt == BIT_LAST) begin
              state <= ST_DONE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_DONE: begin
          state  <= ST_OUTL;
          cycCnt <= '0;
        end
        ST_OUTL: begin
          if (slotEnd) begin
            state  <= ST_OUTR;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_OUTR: begin
          if (slotEnd) begin
            state  <= ST_IDLE;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          cycCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    dpCtrl                = '0;
    dpCtrl.clearResult    = (state == ST_IDLE) && frameTick;
    dpCtrl.captureOut     = (state == ST_IDLE) && frameTick;
    dpCtrl.loadFirstTrial = acqEnd;
    dpCtrl.decideBit      = stepEnd;
    dpCtrl.loadLeft       = (state == ST_DONE);
    dpCtrl.loadRight      = (state == ST_OUTL) && slotEnd;
  end

  assign sampleSwitch = (state == ST_ACQ);
  assign sampleValid  = (state == ST_DONE);
  assign holdLeft     = (state == ST_OUTL) && inHoldWindow;
  assign holdRight    = (state == ST_OUTR) && inHoldWindow;

  // R7
  switch_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleSwitch, holdLeft, holdRight}));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8
  acq_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleSwitch) |-> $past(state) == ST_IDLE);

  // R2
  acq_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleSwitch) |-> state == ST_CONV && bitCnt == '0);

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              compBit,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic [DATA_W-1:0] dacWord,
  output logic [DATA_W-1:0] sampleOut
);

  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] trialMask;
  logic [DATA_W-1:0] leftReg;
  logic [DATA_W-1:0] rightReg;
  logic [DATA_W-1:0] nextResult;
  logic [DATA_W-1:0] nextMask;

  assign nextResult = compBit ? (result | trialMask) : result;
  assign nextMask   = trialMask >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      trialMask <= '0;
      dacWord   <= '0;
      leftReg   <= '0;
      rightReg  <= '0;
    end else begin
      if (dpCtrl.clearResult) begin
        result <= '0;
      end
      if (dpCtrl.captureOut) begin
        leftReg  <= leftIn;
        rightReg <= rightIn;
      end
      if (dpCtrl.loadFirstTrial) begin
        trialMask <= TOP_BIT;
        dacWord   <= TOP_BIT;
      end
      if (dpCtrl.decideBit) begin
        result    <= nextResult;
        trialMask <= nextMask;
        dacWord   <= nextResult | nextMask;
      end
      if (dpCtrl.loadLeft) begin
        dacWord <= leftReg;
      end
      if (dpCtrl.loadRight) begin
        dacWord <= rightReg;
      end
    end
  end

  assign sampleOut = result;

  // R3
  trial_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.decideBit |-> $onehot(trialMask) && ((dacWord & trialMask) != '0));

  // R4
  keep_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.decideBit |=> ((result & $past(trialMask)) != '0) == $past(compBit));

endmodule

// File: rtl/sar_dac_sequencer.sv
module sar_dac_sequencer
  import sar_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ACQ_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 2,
  parameter int HOLD_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              compBit,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic [DATA_W-1:0] dacWord,
  output logic              sampleSwitch,
  output logic              holdLeft,
  output logic              holdRight,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid
);

  dpCtrl_t dpCtrl;

  sar_seq_ctrl #(
    .DATA_W       (DATA_W),
    .ACQ_CYCLES   (ACQ_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .HOLD_CYCLES  (HOLD_CYCLES)
  ) ctrlInst (
    .clk         (clk),
    .rstN        (rstN),
    .frameTick   (frameTick),
    .dpCtrl      (dpCtrl),
    .sampleSwitch(sampleSwitch),
    .holdLeft    (holdLeft),
    .holdRight   (holdRight),
    .sampleValid (sampleValid)
  );

  sar_seq_datapath #(
    .DATA_W(DATA_W)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .compBit  (compBit),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .dacWord  (dacWord),
    .sampleOut(sampleOut)
  );

  // R7
  hold_left_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdLeft |-> $stable(dacWord));

  // R7
  hold_right_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdRight |-> $stable(dacWord));

  // R2
  search_switch_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.decideBit |-> !sampleSwitch);

endmodule

// File: tb/sar_dac_sequencer_test.sv
module sar_dac_sequencer_test;

  localparam int W        = 16;
  localparam int ACQ      = 8;
  localparam int ST       = 2;
  localparam int HC       = 4;
  localparam int SLOT     = ST + HC + 1;
  localparam int CONV_LEN = W * ST;
  localparam int FRAME    = ACQ + CONV_LEN + 1 + 2 * SLOT;

  logic         clk = 1'b0;
  logic         rstN;
  logic         frameTick;
  logic         compBit;
  logic [W-1:0] leftIn, rightIn;
  logic [W-1:0] dacWord, sampleOut;
  logic         sampleSwitch, holdLeft, holdRight, sampleValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sar_dac_sequencer #(
    .DATA_W(W), .ACQ_CYCLES(ACQ), .SETTLE_CYCLES(ST), .HOLD_CYCLES(HC)
  ) uut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .compBit(compBit),
    .leftIn(leftIn), .rightIn(rightIn), .dacWord(dacWord),
    .sampleSwitch(sampleSwitch), .holdLeft(holdLeft), .holdRight(holdRight),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] trialWord(input logic [W-1:0] level, input int k);
    logic [31:0] keepMask;
    keepMask = ~((32'd1 << (W - k)) - 32'd1);
    return W'(({16'd0, level} & keepMask) | (32'd1 << (W - 1 - k)));
  endfunction

  task automatic runFrame(input logic [W-1:0] level, input logic [W-1:0] lWord,
                          input logic [W-1:0] rWord, input bit noisy);
    int rises = 0;
    logic prevSw = 1'b0;
    @(negedge clk);
    frameTick = 1'b1;
    leftIn    = lWord;
    rightIn   = rWord;
    compBit   = 1'b0;
    for (int n = 0; n < FRAME; n++) begin
      @(negedge clk);
      frameTick = (noisy && n < FRAME - 1) ? 1'($urandom_range(0, 1)) : 1'b0;
      leftIn    = W'($urandom);
      rightIn   = W'($urandom);
      compBit   = (level >= dacWord);
      if (sampleSwitch && !prevSw) rises++;
      prevSw = sampleSwitch;
      check(sampleSwitch == (n < ACQ), "R2", "sampleSwitch", sampleSwitch, n < ACQ);
      check(sampleValid == (n == ACQ + CONV_LEN), "R5", "sampleValid",
            sampleValid, n == ACQ + CONV_LEN);
      if (n >= ACQ && n < ACQ + CONV_LEN) begin
        check(dacWord == trialWord(level, (n - ACQ) / ST), "R3", "trial dacWord",
              dacWord, trialWord(level, (n - ACQ) / ST));
      end
      if (n == ACQ + CONV_LEN) begin
        check(sampleOut == level, "R4", "converted word", sampleOut, level);
      end
      if (n > ACQ + CONV_LEN) begin
        int s = n - (ACQ + CONV_LEN + 1);
        int m = s % SLOT;
        bit win = (m >= ST) && (m < ST + HC);
        bit isLeft = (s < SLOT);
        check(dacWord == (isLeft ? lWord : rWord), "R6", "slot dacWord",
              dacWord, isLeft ? lWord : rWord);
        check(holdLeft == (isLeft && win), "R7", "holdLeft", holdLeft, isLeft && win);
        check(holdRight == (!isLeft && win), "R7", "holdRight", holdRight, !isLeft && win);
      end else begin
        check(!holdLeft && !holdRight, "R7", "hold outside slots",
              {holdLeft, holdRight}, 0);
      end
    end
    check(rises == 1, "R8", "sampleSwitch rises per frame", rises, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!sampleSwitch && !holdLeft && !holdRight && !sampleValid, "R9",
            "idle switches", {sampleSwitch, holdLeft, holdRight, sampleValid}, 0);
      check(dacWord == rWord, "R9", "idle dacWord", dacWord, rWord);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corners [6];
    void'($urandom(32'd20250917));
    rstN = 1'b0; frameTick = 1'b0; compBit = 1'b0; leftIn = '0; rightIn = '0;
    repeat (3) @(negedge clk);
    check(dacWord == '0, "R1", "dacWord in reset", dacWord, 0);
    check(!sampleSwitch && !holdLeft && !holdRight && !sampleValid, "R1",
          "switches in reset", {sampleSwitch, holdLeft, holdRight, sampleValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(dacWord == '0 && !sampleSwitch && !holdLeft && !holdRight && !sampleValid,
          "R1", "state after reset", dacWord, 0);

    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h7FFF; corners[4] = 16'hA5A5; corners[5] = 16'h0001;
    for (int i = 0; i < 6; i++) begin
      runFrame(corners[i], 16'h1234 + 16'(i), 16'hFEDC - 16'(i), 1'b0);
    end
    runFrame(16'h5A5A, 16'hFFFF, 16'h0000, 1'b1);
    for (int i = 0; i < 30; i++) begin
      runFrame(W'($urandom), W'($urandom), W'($urandom), (i % 3) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule